// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the serial test port of a chip. It follows the sixteen-state test access port sequence driven by a test clock and a mode-select line. It holds a 4-bit instruction register, a 1-bit bypass stage and a 32-bit identification register. The loaded instruction decides which data path sits between the serial input and the serial output: the bypass stage, the identification register, or an external boundary-scan chain.

The block does not contain the boundary-scan cells. It sends them three mode levels and the capture, shift and update strobes for the chain. The mode levels are test mode, output clamp and output high-impedance. The chain's serial output comes back in on `bsr_so`, and the chain takes its serial input directly from `tdi`.

The serial output changes only on the falling test clock edge. It is driven only while a shift state is active.

Top module: `tap_port`

## Requirements
- R1: `tms` and `tdi` are sampled on the rising edge of `tck`. `tdo` changes only after a falling edge of `tck`. `tdo_oe` is 1 exactly while the controller is in Shift-IR or Shift-DR.
- R2: `trst_n` low, or five rising `tck` edges with `tms` high, puts the controller in Test-Logic-Reset. There the instruction becomes IDCODE (1110), or BYPASS (1111) when `HAS_IDCODE` is 0. `test_mode`, `clamp_hold` and `out_hiz` are then 0.
- R3: Capture-IR loads 0001 into the instruction shift stage. The stage shifts out least significant bit first on `tdo`.
- R4: The decoded instruction and every mode output change only when the controller leaves Update-IR (or on reset). They do not change during Capture-IR, Shift-IR or Exit1-IR.
- R5: EXTEST (0000), SAMPLE/PRELOAD (0011) and INTEST (1100) place the external chain between `tdi` and `tdo`. Data shifted in on `tdi` appears on `tdo` after the chain's length.
- R6: IDCODE (1110) selects the 32-bit identification register. It captures `ID_VALUE` (bit 0 is 1) in Capture-DR and shifts it out least significant bit first.
- R7: BYPASS (1111), CLAMP (0101), CLAMPZ (1001) and every undefined opcode select the bypass stage. The stage captures 0 and delays `tdi` by one clock.
- R8: `test_mode` is 1 only under EXTEST and INTEST. It stays 0 under SAMPLE/PRELOAD.
- R9: `clamp_hold` is 1 only under CLAMP, and `out_hiz` is 1 only under CLAMPZ. At most one of `test_mode`, `clamp_hold`, `out_hiz` is 1 at a time.
- R10: `bs_capture`, `bs_shift` and `bs_update` are 1 only in Capture-DR, Shift-DR and Update-DR respectively, and only while the chain is selected. There is one `bs_update` per DR scan under a chain-selecting instruction and none otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, changes on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| bs_capture | output | 1 | Chain capture strobe |
| bs_shift | output | 1 | Chain shift strobe |
| bs_update | output | 1 | Chain update strobe |
| test_mode | output | 1 | Boundary cells drive from their update latches |
| clamp_hold | output | 1 | Outputs held from update latches, bypass selected |
| out_hiz | output | 1 | Global output disable for boundary-driven pins |

## Verification
Each of the seven defined opcodes and one undefined opcode is loaded, and a 32-bit pattern is then shifted through the data path. The 0-then-delayed pattern identifies the bypass stage. The fixed constant identifies the identification register. An 8-bit capture value followed by the delayed input identifies the external chain. These patterns, together with the mode levels and the update-strobe count, separate every row of the opcode map. Directed sequences cover the following: the state after reset, the return to reset through five high `tms` cycles, the mode outputs holding steady until Update-IR, and `tdo` staying unchanged across a rising edge.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    ST_TLR,    ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BYP = 2'd0,
    PATH_ID  = 2'd1,
    PATH_BS  = 2'd2
  } dr_path_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0011;
  localparam logic [IR_W-1:0] OP_CLAMP   = 4'b0101;
  localparam logic [IR_W-1:0] OP_CLAMPZ  = 4'b1001;
  localparam logic [IR_W-1:0] OP_INTEST  = 4'b1100;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'b1110;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef struct packed {
    dr_path_e path;
    logic     test;
    logic     clamp;
    logic     hiz;
  } ir_dec_t;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_TLR;
    else        state <= state_d;
  end

  // Checker: run of consecutive high tms samples, saturating at 5.
  logic [2:0] hi_run_q;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)       hi_run_q <= 3'd0;
    else if (!tms)    hi_run_q <= 3'd0;
    else if (hi_run_q != 3'd5) hi_run_q <= hi_run_q + 3'd1;
  end

  // R2
  five_high_reset_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (hi_run_q == 3'd5) |-> (state == ST_TLR));

  // R2
  tlr_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_TLR && tms) |=> (state == ST_TLR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter bit HAS_IDCODE = 1'b1
) (
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tdi,
  input  tap_state_e state,
  output logic       ir_so,
  output ir_dec_t    dec
);

  localparam logic [IR_W-1:0] RESET_OP = HAS_IDCODE ? OP_IDCODE : OP_BYPASS;

  logic [IR_W-1:0] ir_sr_q, ir_sr_d;
  logic [IR_W-1:0] ir_q, ir_d;
  logic            sr_en, ir_en;

  // Shift stage: capture the fixed pattern, shift LSB out, tdi in at MSB.
  always_comb begin
    sr_en   = 1'b0;
    ir_sr_d = ir_sr_q;
    if (state == ST_CAP_IR) begin
      sr_en   = 1'b1;
      ir_sr_d = IR_CAPTURE;
    end else if (state == ST_SH_IR) begin
      sr_en   = 1'b1;
      ir_sr_d = {tdi, ir_sr_q[IR_W-1:1]};
    end
  end

  // Active instruction: loaded at the edge leaving Update-IR.
  always_comb begin
    ir_en = 1'b0;
    ir_d  = ir_q;
    if (state == ST_TLR) begin
      ir_en = 1'b1;
      ir_d  = RESET_OP;
    end else if (state == ST_UPD_IR) begin
      ir_en = 1'b1;
      ir_d  = ir_sr_q;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     ir_sr_q <= IR_CAPTURE;
    else if (sr_en) ir_sr_q <= ir_sr_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     ir_q <= RESET_OP;
    else if (ir_en) ir_q <= ir_d;
  end

  assign ir_so = ir_sr_q[0];

  always_comb begin
    dec = '{path: PATH_BYP, test: 1'b0, clamp: 1'b0, hiz: 1'b0};
    unique case (ir_q)
      OP_EXTEST: begin dec.path = PATH_BS; dec.test = 1'b1; end
      OP_SAMPLE: dec.path = PATH_BS;
      OP_INTEST: begin dec.path = PATH_BS; dec.test = 1'b1; end
      OP_CLAMP:  dec.clamp = 1'b1;
      OP_CLAMPZ: dec.hiz   = 1'b1;
      OP_IDCODE: dec.path  = HAS_IDCODE ? PATH_ID : PATH_BYP;
      default:   dec.path  = PATH_BYP;
    endcase
  end

  // R3
  ir_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_IR) |=> (ir_sr_q == IR_CAPTURE));

  // R4
  ir_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state != ST_UPD_IR && state != ST_TLR) |=> $stable(ir_q));

  // R2
  ir_reset_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_TLR) |=> (ir_q == RESET_OP));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int          ID_W     = 32,
  parameter logic [31:0] ID_VALUE = 32'h4F1C_3A57
) (
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tdi,
  input  tap_state_e state,
  input  dr_path_e   path,
  output logic       byp_so,
  output logic       id_so
);

  localparam logic [ID_W-1:0] ID_CONST = ID_VALUE[ID_W-1:0];

  logic            byp_q, byp_d, byp_en;
  logic [ID_W-1:0] id_q, id_d;
  logic            id_en;

  always_comb begin
    byp_en = 1'b0;
    byp_d  = byp_q;
    if (path == PATH_BYP) begin
      if (state == ST_CAP_DR) begin
        byp_en = 1'b1;
        byp_d  = 1'b0;
      end else if (state == ST_SH_DR) begin
        byp_en = 1'b1;
        byp_d  = tdi;
      end
    end
  end

  always_comb begin
    id_en = 1'b0;
    id_d  = id_q;
    if (path == PATH_ID) begin
      if (state == ST_CAP_DR) begin
        id_en = 1'b1;
        id_d  = ID_CONST;
      end else if (state == ST_SH_DR) begin
        id_en = 1'b1;
        id_d  = {tdi, id_q[ID_W-1:1]};
      end
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     id_q <= ID_CONST;
    else if (id_en) id_q <= id_d;
  end

  assign byp_so = byp_q;
  assign id_so  = id_q[0];

  // R7
  byp_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR && path == PATH_BYP) |=> (byp_q == 1'b0));

  // R6
  id_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR && path == PATH_ID) |=> (id_q == ID_CONST && id_q[0]));

endmodule

// File: rtl/tap_port.sv
module tap_port
  import tap_pkg::*;
#(
  parameter bit          HAS_IDCODE = 1'b1,
  parameter int          ID_W       = 32,
  parameter logic [31:0] ID_VALUE   = 32'h4F1C_3A57
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic bsr_so,
  output logic tdo,
  output logic tdo_oe,
  output logic bs_capture,
  output logic bs_shift,
  output logic bs_update,
  output logic test_mode,
  output logic clamp_hold,
  output logic out_hiz
);

  // Reset: asserted asynchronously, released on tck.
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  tap_state_e state;
  ir_dec_t    dec;
  logic       ir_so, byp_so, id_so;

  tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  tap_ir #(.HAS_IDCODE(HAS_IDCODE)) u_ir (
    .tck   (tck),
    .rst_n (rst_n),
    .tdi   (tdi),
    .state (state),
    .ir_so (ir_so),
    .dec   (dec)
  );

  tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck    (tck),
    .rst_n  (rst_n),
    .tdi    (tdi),
    .state  (state),
    .path   (dec.path),
    .byp_so (byp_so),
    .id_so  (id_so)
  );

  logic bs_sel;
  assign bs_sel     = (dec.path == PATH_BS);
  assign bs_capture = bs_sel && (state == ST_CAP_DR);
  assign bs_shift   = bs_sel && (state == ST_SH_DR);
  assign bs_update  = bs_sel && (state == ST_UPD_DR);
  assign test_mode  = dec.test;
  assign clamp_hold = dec.clamp;
  assign out_hiz    = dec.hiz;

  // Serial output select, retimed on the falling edge.
  logic tdo_d, oe_d;
  always_comb begin
    tdo_d = 1'b0;
    oe_d  = 1'b0;
    if (state == ST_SH_IR) begin
      tdo_d = ir_so;
      oe_d  = 1'b1;
    end else if (state == ST_SH_DR) begin
      oe_d = 1'b1;
      unique case (dec.path)
        PATH_BS: tdo_d = bsr_so;
        PATH_ID: tdo_d = id_so;
        default: tdo_d = byp_so;
      endcase
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_oe <= oe_d;
    end
  end

  // R1
  tdo_oe_state_chk: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe == (state == ST_SH_IR || state == ST_SH_DR));

  // R1
  tdo_rise_stable_chk: assert property (@(posedge tck) disable iff (!rst_n)
    !tdo_oe |-> (tdo == 1'b0));

  // R9
  mode_excl_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({test_mode, clamp_hold, out_hiz}));

  // R10
  strobe_excl_chk: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({bs_capture, bs_shift, bs_update}));

  // R10
  strobe_path_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (bs_capture || bs_shift || bs_update) |-> (dec.path == PATH_BS));

  // R8
  test_mode_path_chk: assert property (@(posedge tck) disable iff (!rst_n)
    test_mode |-> (dec.path == PATH_BS));

endmodule

// File: tb/sim_tap_port.sv
`timescale 1ns/1ps
module sim_tap_port;

  localparam logic [31:0] EXP_ID   = 32'h4F1C_3A57;
  localparam logic [7:0]  BS_CAPV  = 8'hA5;
  localparam int          BS_LEN   = 8;

  // Vector: {opcode[3:0], path[1:0] (0 bypass, 1 id, 2 chain), test, clamp, hiz}
  localparam int NV = 8;
  localparam logic [8:0] VEC [NV] = '{
    {4'b0000, 2'd2, 1'b1, 1'b0, 1'b0},
    {4'b0011, 2'd2, 1'b0, 1'b0, 1'b0},
    {4'b0101, 2'd0, 1'b0, 1'b1, 1'b0},
    {4'b1001, 2'd0, 1'b0, 1'b0, 1'b1},
    {4'b1100, 2'd2, 1'b1, 1'b0, 1'b0},
    {4'b1110, 2'd1, 1'b0, 1'b0, 1'b0},
    {4'b1111, 2'd0, 1'b0, 1'b0, 1'b0},
    {4'b0111, 2'd0, 1'b0, 1'b0, 1'b0}
  };

  logic tck = 1'b0;
  logic trst_n, tms, tdi;
  logic tdo, tdo_oe, bs_capture, bs_shift, bs_update;
  logic test_mode, clamp_hold, out_hiz;
  logic bsr_so;

  int n_checks = 0;
  int n_fail   = 0;
  int upd_cnt  = 0;

  always #4 tck = ~tck;

  // Model of an 8-cell external chain fed from tdi.
  logic [BS_LEN-1:0] chain;
  always @(posedge tck) begin
    if (bs_capture)    chain <= BS_CAPV;
    else if (bs_shift) chain <= {tdi, chain[BS_LEN-1:1]};
    if (bs_update)     upd_cnt <= upd_cnt + 1;
  end
  assign bsr_so = chain[0];

  tap_port #(.HAS_IDCODE(1'b1), .ID_W(32), .ID_VALUE(EXP_ID)) u0 (
    .tck        (tck),
    .trst_n     (trst_n),
    .tms        (tms),
    .tdi        (tdi),
    .bsr_so     (bsr_so),
    .tdo        (tdo),
    .tdo_oe     (tdo_oe),
    .bs_capture (bs_capture),
    .bs_shift   (bs_shift),
    .bs_update  (bs_update),
    .test_mode  (test_mode),
    .clamp_hold (clamp_hold),
    .out_hiz    (out_hiz)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic d);
    tms = t;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  // Called in Capture-xR; leaves the controller in Exit1-xR.
  task automatic scan(input int n, input logic [31:0] din,
                      output logic [31:0] dout, output logic oe_ok);
    dout  = '0;
    step(1'b0, 1'b0);
    dout[0] = tdo;
    oe_ok   = tdo_oe;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      if (i < n - 1) begin
        dout[i+1] = tdo;
        oe_ok     = oe_ok & tdo_oe;
      end else begin
        oe_ok = oe_ok & !tdo_oe;
      end
    end
  endtask

  task automatic load_ir(input logic [3:0] op, output logic [31:0] cap,
                         output logic oe_ok);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    scan(4, {28'd0, op}, cap, oe_ok);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic dr_scan(input logic [31:0] din, output logic [31:0] dout,
                         output logic oe_ok);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    scan(32, din, dout, oe_ok);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  function automatic logic [31:0] expect_dr(input logic [1:0] path,
                                            input logic [31:0] din);
    if (path == 2'd1) return EXP_ID;
    if (path == 2'd2) return {din[31-BS_LEN:0], BS_CAPV};
    return {din[30:0], 1'b0};
  endfunction

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] got, exp, din;
    logic        ok;
    int          u0_cnt;
    trst_n = 1'b0;
    tms    = 1'b1;
    tdi    = 1'b0;
    repeat (3) @(negedge tck);
    #1;
    trst_n = 1'b1;
    repeat (3) step(1'b1, 1'b0);

    // R2: reset state
    chk(!tdo_oe && !test_mode && !clamp_hold && !out_hiz, "R2 reset outputs",
        {28'd0, tdo_oe, test_mode, clamp_hold, out_hiz}, 32'd0);
    step(1'b0, 1'b0);
    dr_scan(32'h0, got, ok);
    chk(got == EXP_ID, "R2 R6 reset instruction reads id", got, EXP_ID);
    chk(!tdo_oe, "R1 tdo disabled in idle", {31'd0, tdo_oe}, 32'd0);

    // Vector table walk.
    for (int v = 0; v < NV; v++) begin
      load_ir(VEC[v][8:5], got, ok);
      chk(got[3:0] == 4'b0001, "R3 capture-ir pattern", got, 32'h1);
      chk(ok, "R1 tdo_oe during ir shift", {31'd0, ok}, 32'd1);
      chk({test_mode, clamp_hold, out_hiz} == VEC[v][2:0], "R8 R9 mode outputs",
          {29'd0, test_mode, clamp_hold, out_hiz}, {29'd0, VEC[v][2:0]});
      din    = 32'hC3A5_96F0 ^ (32'h0101_0101 * v);
      u0_cnt = upd_cnt;
      dr_scan(din, got, ok);
      exp = expect_dr(VEC[v][4:3], din);
      case (VEC[v][4:3])
        2'd1:    chk(got == exp, "R6 id register data", got, exp);
        2'd2:    chk(got == exp, "R5 chain data", got, exp);
        default: chk(got == exp, "R7 bypass data", got, exp);
      endcase
      chk(ok, "R1 tdo_oe during dr shift", {31'd0, ok}, 32'd1);
      exp = (VEC[v][4:3] == 2'd2) ? 32'd1 : 32'd0;
      chk((upd_cnt - u0_cnt) == int'(exp), "R10 update strobe count",
          upd_cnt - u0_cnt, exp);
    end

    // R4: mode outputs hold until Update-IR.
    load_ir(4'b0000, got, ok);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    scan(4, 32'hF, got, ok);
    chk(test_mode, "R4 test_mode held in exit1-ir", {31'd0, test_mode}, 32'd1);
    step(1'b1, 1'b0);
    chk(test_mode, "R4 test_mode held in update-ir", {31'd0, test_mode}, 32'd1);
    step(1'b0, 1'b0);
    chk(!test_mode, "R4 test_mode cleared after update", {31'd0, test_mode}, 32'd0);

    // R1: tdo does not move on the rising edge.
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk(tdo == 1'b0 && tdo_oe, "R7 bypass captured zero", {31'd0, tdo}, 32'd0);
    tms = 1'b0;
    tdi = 1'b1;
    @(posedge tck);
    #1;
    chk(tdo == 1'b0, "R1 tdo stable after rising edge", {31'd0, tdo}, 32'd0);
    @(negedge tck);
    #1;
    chk(tdo == 1'b1, "R1 tdo updated after falling edge", {31'd0, tdo}, 32'd1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);

    // R2: five tms-high cycles return to reset from a loaded EXTEST.
    load_ir(4'b0000, got, ok);
    chk(test_mode, "R8 extest test_mode before reset", {31'd0, test_mode}, 32'd1);
    repeat (5) step(1'b1, 1'b0);
    chk(!test_mode, "R2 tms reset clears mode", {31'd0, test_mode}, 32'd0);
    step(1'b0, 1'b0);
    dr_scan(32'hFFFF_0000, got, ok);
    chk(got == EXP_ID, "R2 tms reset restores id", got, EXP_ID);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule